// File: doc/BRIEF.md
# Double-Buffered BCD Clock Calendar

This block keeps calendar time in packed BCD: century, year, month, date, day-of-week, hours, minutes and seconds, with hours running from 00 to 23. A prescaler divides an oscillator enable (`osc_en`) down to one step per second. The step advances a counting bank inside the block. Month lengths and leap years are handled in hardware, and the counting bank keeps advancing whatever software does with the visible registers.

Software sees a second, visible bank through a byte-wide register port. A two-bit control register drives a four-state machine.

- **TRACK**: both control bits are clear. Each second step copies the new count into the visible bank.
- **FREEZE**: the SNAP bit is set. Copies stop, so software reads a stable snapshot. The next second step after SNAP clears refreshes the visible bank.
- **EDIT**: the EDIT bit is set. Software may overwrite the time fields of the visible bank.
- **COMMIT**: lasts one cycle. In it the visible bank is loaded into the counting bank and the prescaler restarts.

The transitions are as follows.

- Any state goes to EDIT when the control value being written (or held) has EDIT set.
- EDIT goes to COMMIT when EDIT clears.
- TRACK, FREEZE and COMMIT go to FREEZE or TRACK according to SNAP.

Top module: `rtc_dual_bank`

## Requirements
- R1: After reset the control register reads 00 and the visible fields read century 20, year 00, month 01, date 01, day 01, and 00:00:00.
- R2: A second step occurs on every PRESCALE-th cycle with `osc_en` high. Cycles with `osc_en` low do not count. Each step advances seconds by one in BCD.
- R3: Seconds wrap 59 to 00 and carry into minutes. Minutes wrap 59 to 00 and carry into hours. Hours wrap 23 to 00 and carry into the date.
- R4: Months 04, 06, 09 and 11 end on day 30, and the other non-February months end on day 31. Past the last day, the date returns to 01 and the month advances.
- R5: February ends on 29 when the year is divisible by 4, except that year 00 needs the century to be divisible by 4 as well. Otherwise February ends on 28.
- R6: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00 and advances the century.
- R7: Day-of-week runs 01 to 07, wraps to 01, and steps in the same second as the date.
- R8: While SNAP (control bit 0) is 1, the visible bank holds and the counting bank keeps advancing. After SNAP clears, the first second step shows the current count.
- R9: Writes to time registers (addresses 1 to 8) take effect only while EDIT (control bit 1) is 1, and are ignored otherwise.
- R10: When EDIT goes from 1 to 0, the counting bank is loaded from the visible bank on the following clock. The prescaler restarts from zero in that same clock, so the next step needs a full PRESCALE enabled cycles.
- R11: The register map is address 0 control {6'b0, EDIT, SNAP}, then seconds 1, minutes 2, hours 3, day 4, date 5, month 6, year 7 and century 8. Reads return that register, and unmapped addresses read 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | Oscillator enable, counted by the prescaler |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |

## Verification
The bench presets the clock just before each rollover: the end of a 30-day and a 31-day month, 28 February in leap, non-leap, century-leap and century-non-leap years, and 31 December 1999. A design with a wrong carry chain or leap rule would show the wrong date, month or century after one second. It freezes the snapshot over several steps and checks that nothing appears until the first step after release. A missing refresh or a leaking copy would show up as a frozen or early seconds value. It also checks that a commit restarts the prescaler: a design that kept the old count would step one or more cycles early.

// File: rtl/rtc_dual_bank_pkg.sv
package rtc_dual_bank_pkg;

    localparam int NUM_FIELDS = 8;
    localparam int CTRL_W     = 2;
    localparam int SNAP_BIT   = 0;
    localparam int EDIT_BIT   = 1;

    typedef enum logic [1:0] {
        ST_TRACK  = 2'd0,
        ST_FREEZE = 2'd1,
        ST_EDIT   = 2'd2,
        ST_COMMIT = 2'd3
    } rtc_state_e;

    // Packed so that field k sits at bits [8k+7:8k]; register address is k+1.
    typedef struct packed {
        logic [7:0] cen;
        logic [7:0] yr;
        logic [7:0] mon;
        logic [7:0] date;
        logic [7:0] dow;
        logic [7:0] hr;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_time_t;

    localparam rtc_time_t RESET_TIME = '{
        cen: 8'h20, yr: 8'h00, mon: 8'h01, date: 8'h01,
        dow: 8'h01, hr: 8'h00, min: 8'h00, sec: 8'h00
    };

    // Returns {wrapped, next} for one BCD step between first and last.
    function automatic logic [8:0] bcd_step(input logic [7:0] v,
                                            input logic [7:0] last,
                                            input logic [7:0] first);
        logic [3:0] tens_p1;
        logic [3:0] ones_p1;
        tens_p1 = v[7:4] + 4'd1;
        ones_p1 = v[3:0] + 4'd1;
        if (v == last)
            return {1'b1, first};
        else if (v[3:0] >= 4'd9)
            return {1'b0, tens_p1, 4'd0};
        else
            return {1'b0, v[7:4], ones_p1};
    endfunction

    // A two-digit BCD value is a multiple of four when an even tens digit
    // meets 0/4/8 or an odd tens digit meets 2/6.
    function automatic logic bcd_div4(input logic [7:0] v);
        if (v[4])
            return (v[3:0] == 4'd2) || (v[3:0] == 4'd6);
        else
            return (v[3:0] == 4'd0) || (v[3:0] == 4'd4) || (v[3:0] == 4'd8);
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_en,
    input  logic clear,
    output logic sec_tick
);
    localparam int CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);

    logic [CNT_W-1:0] cnt_q;

    assign sec_tick = osc_en && !clear && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear || sec_tick)
            cnt_q <= '0;
        else if (osc_en)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    // R2
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R10
    clear_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

endmodule

// File: rtl/rtc_advance.sv
module rtc_advance
    import rtc_dual_bank_pkg::*;
(
    input  rtc_time_t cur,
    output rtc_time_t nxt
);
    logic [7:0] month_end;
    logic       leap;
    logic [8:0] sec_s, min_s, hr_s, dow_s, date_s, mon_s, yr_s, cen_s;

    always_comb begin
        leap = bcd_div4(cur.yr) && ((cur.yr != 8'h00) || bcd_div4(cur.cen));
        unique case (cur.mon)
            8'h02:                      month_end = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: month_end = 8'h30;
            default:                    month_end = 8'h31;
        endcase
    end

    always_comb begin
        sec_s  = bcd_step(cur.sec,  8'h59, 8'h00);
        min_s  = bcd_step(cur.min,  8'h59, 8'h00);
        hr_s   = bcd_step(cur.hr,   8'h23, 8'h00);
        dow_s  = bcd_step(cur.dow,  8'h07, 8'h01);
        date_s = bcd_step(cur.date, month_end, 8'h01);
        mon_s  = bcd_step(cur.mon,  8'h12, 8'h01);
        yr_s   = bcd_step(cur.yr,   8'h99, 8'h00);
        cen_s  = bcd_step(cur.cen,  8'h99, 8'h00);
    end

    always_comb begin
        nxt     = cur;
        nxt.sec = sec_s[7:0];
        if (sec_s[8]) begin
            nxt.min = min_s[7:0];
            if (min_s[8]) begin
                nxt.hr = hr_s[7:0];
                if (hr_s[8]) begin
                    nxt.dow  = dow_s[7:0];
                    nxt.date = date_s[7:0];
                    if (date_s[8]) begin
                        nxt.mon = mon_s[7:0];
                        if (mon_s[8]) begin
                            nxt.yr = yr_s[7:0];
                            if (yr_s[8])
                                nxt.cen = cen_s[7:0];
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rtc_ctrl_fsm.sv
module rtc_ctrl_fsm
    import rtc_dual_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output rtc_state_e        state_q,
    output logic              copy_en,
    output logic              edit_en,
    output logic              commit
);
    logic [CTRL_W-1:0] ctrl_d;
    rtc_state_e        state_d;

    always_comb begin
        ctrl_d = ctrl_wr ? ctrl_wdata : ctrl_q;
        unique case (state_q)
            ST_EDIT:
                state_d = ctrl_d[EDIT_BIT] ? ST_EDIT : ST_COMMIT;
            ST_TRACK, ST_FREEZE, ST_COMMIT:
                state_d = ctrl_d[EDIT_BIT] ? ST_EDIT :
                          (ctrl_d[SNAP_BIT] ? ST_FREEZE : ST_TRACK);
            default:
                state_d = ST_TRACK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_TRACK;
            ctrl_q  <= '0;
        end else begin
            state_q <= state_d;
            ctrl_q  <= ctrl_d;
        end
    end

    always_comb begin
        copy_en = 1'b0;
        edit_en = 1'b0;
        commit  = 1'b0;
        unique case (state_q)
            ST_TRACK:  copy_en = 1'b1;
            ST_FREEZE: ;
            ST_EDIT:   edit_en = 1'b1;
            ST_COMMIT: commit  = 1'b1;
            default:   ;
        endcase
    end

    // R10
    commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |=> (state_q != ST_COMMIT));

    // R9
    edit_matches_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[EDIT_BIT] == (state_q == ST_EDIT));

    // R8
    snap_no_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[SNAP_BIT] |-> (state_q != ST_TRACK));

endmodule

// File: rtl/rtc_dual_bank.sv
module rtc_dual_bank
    import rtc_dual_bank_pkg::*;
#(
    parameter int PRESCALE = 32768,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    localparam int TIME_W = 8 * NUM_FIELDS;

    rtc_state_e        state_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              copy_en, edit_en, commit, sec_tick;
    logic              ctrl_wr;
    rtc_time_t         cnt_q, cnt_nxt;
    logic [TIME_W-1:0] vis_vec;
    logic [7:0]        vis_q [NUM_FIELDS];

    assign ctrl_wr = bus_wr && (bus_addr == '0);

    rtc_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (bus_wdata[CTRL_W-1:0]),
        .ctrl_q     (ctrl_q),
        .state_q    (state_q),
        .copy_en    (copy_en),
        .edit_en    (edit_en),
        .commit     (commit)
    );

    rtc_prescaler #(.PRESCALE(PRESCALE)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_en   (osc_en),
        .clear    (commit),
        .sec_tick (sec_tick)
    );

    rtc_advance u_adv (
        .cur (cnt_q),
        .nxt (cnt_nxt)
    );

    // Counting bank: loaded on commit, otherwise stepped each second.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= RESET_TIME;
        else if (commit)
            cnt_q <= rtc_time_t'(vis_vec);
        else if (sec_tick)
            cnt_q <= cnt_nxt;
    end

    // Visible bank: one register per field.
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_vis
        localparam logic [7:0] RST_VAL = RESET_TIME[8*g +: 8];
        logic hit;
        assign hit = bus_wr && edit_en && (int'(bus_addr) == g + 1);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                vis_q[g] <= RST_VAL;
            else if (copy_en && sec_tick)
                vis_q[g] <= cnt_nxt[8*g +: 8];
            else if (hit)
                vis_q[g] <= bus_wdata;
        end
        assign vis_vec[8*g +: 8] = vis_q[g];
    end

    always_comb begin
        if (bus_addr == '0)
            bus_rdata = {{(8 - CTRL_W){1'b0}}, ctrl_q};
        else if (int'(bus_addr) <= NUM_FIELDS)
            bus_rdata = vis_vec[8*(int'(bus_addr) - 1) +: 8];
        else
            bus_rdata = 8'h00;
    end

    // R8
    vis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_TRACK) && !(bus_wr && state_q == ST_EDIT)) |=> $stable(vis_vec));

    // R10
    commit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (cnt_q == $past(rtc_time_t'(vis_vec))));

    // R2
    tick_moves_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> (cnt_q.sec != $past(cnt_q.sec)));

    // R9
    no_edit_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (state_q != ST_EDIT) && !sec_tick) |=> $stable(vis_vec));

endmodule

// File: tb/test_rtc_dual_bank.sv
`timescale 1ns/1ps
module test_rtc_dual_bank;
    localparam int P = 4;

    typedef int fld_t [1:8];

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    rtc_dual_bank #(.PRESCALE(P), .ADDR_W(4)) i_rtc_dual_bank (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // Reference model (decimal integers; 1 sec .. 8 century by address)
    fld_t m_cnt, m_vis;
    int   m_ctrl, m_st, m_pre;   // m_st: 0 track, 1 freeze, 2 edit, 3 commit

    function automatic fld_t reset_fields();
        fld_t f;
        f[1] = 0; f[2] = 0; f[3] = 0; f[4] = 1;
        f[5] = 1; f[6] = 1; f[7] = 0; f[8] = 20;
        return f;
    endfunction

    function automatic int month_days(int mon, int yr, int cen);
        bit leap;
        leap = (yr % 4 == 0) && (yr != 0 || cen % 4 == 0);
        if (mon == 2) return leap ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic fld_t one_second(fld_t t);
        fld_t r = t;
        r[1] = r[1] + 1;
        if (r[1] == 60) begin
            r[1] = 0; r[2] = r[2] + 1;
            if (r[2] == 60) begin
                r[2] = 0; r[3] = r[3] + 1;
                if (r[3] == 24) begin
                    r[3] = 0;
                    r[4] = (r[4] == 7) ? 1 : r[4] + 1;
                    if (r[5] == month_days(r[6], r[7], r[8])) begin
                        r[5] = 1; r[6] = r[6] + 1;
                        if (r[6] == 13) begin
                            r[6] = 1; r[7] = r[7] + 1;
                            if (r[7] == 100) begin
                                r[7] = 0; r[8] = (r[8] + 1) % 100;
                            end
                        end
                    end else begin
                        r[5] = r[5] + 1;
                    end
                end
            end
        end
        return r;
    endfunction

    function automatic int to_bcd(int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic int from_bcd(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int model_read(int a);
        if (a == 0) return m_ctrl;
        if (a >= 1 && a <= 8) return to_bcd(m_vis[a]);
        return 0;
    endfunction

    initial begin
        m_cnt = reset_fields(); m_vis = reset_fields();
        m_ctrl = 0; m_st = 0; m_pre = 0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = reset_fields(); m_vis = reset_fields();
            m_ctrl = 0; m_st = 0; m_pre = 0;
        end else begin
            bit   tick;
            int   nctrl;
            int   a;
            fld_t adv;
            a     = int'(bus_addr);
            tick  = (m_st != 3) && osc_en && (m_pre == P - 1);
            adv   = one_second(m_cnt);
            if (m_st == 3) m_pre = 0;
            else if (tick) m_pre = 0;
            else if (osc_en) m_pre = m_pre + 1;
            if (m_st == 0 && tick) m_vis = adv;
            if (bus_wr && m_st == 2 && a >= 1 && a <= 8) m_vis[a] = from_bcd(bus_wdata);
            if (m_st == 3) m_cnt = m_vis;
            else if (tick) m_cnt = adv;
            nctrl = (bus_wr && a == 0) ? int'(bus_wdata[1:0]) : m_ctrl;
            if (nctrl[1]) m_st = 2;
            else if (m_st == 2) m_st = 3;
            else if (nctrl[0]) m_st = 1;
            else m_st = 0;
            m_ctrl = nctrl;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            int exp_v;
            exp_v = model_read(int'(bus_addr));
            checks++;
            if (int'(bus_rdata) != exp_v) begin
                errors++;
                $display("FAIL %s model compare addr=%0d actual=%02h expected=%02h",
                         (bus_addr == 0) ? "R11" : "R3", bus_addr, bus_rdata, exp_v);
            end
        end
    end

    task automatic expect_reg(input int a, input int exp_v, input string tag);
        bus_addr = 4'(a);
        @(negedge clk);
        checks++;
        if (int'(bus_rdata) != exp_v) begin
            errors++;
            $display("FAIL %s addr=%0d actual=%02h expected=%02h", tag, a, bus_rdata, exp_v);
        end
        @(posedge clk); #2;
    endtask

    task automatic wr_reg(input int a, input int d);
        bus_addr = 4'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
        @(posedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            bus_addr = 4'(i % 9);
            @(posedge clk); #2;
        end
    endtask

    task automatic run_osc(input int n);
        osc_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            bus_addr = 4'(i % 9);
            @(posedge clk); #2;
        end
        osc_en = 1'b0;
    endtask

    // fields passed as BCD bytes: cen yr mon date dow hr min sec
    task automatic set_time(input int c, input int y, input int mo, input int d,
                            input int w, input int h, input int mi, input int s);
        wr_reg(0, 2);
        wr_reg(8, c); wr_reg(7, y); wr_reg(6, mo); wr_reg(5, d);
        wr_reg(4, w); wr_reg(3, h); wr_reg(2, mi); wr_reg(1, s);
        wr_reg(0, 0);
        idle(1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        expect_reg(0, 8'h00, "R1");
        expect_reg(1, 8'h00, "R1");
        expect_reg(2, 8'h00, "R1");
        expect_reg(3, 8'h00, "R1");
        expect_reg(4, 8'h01, "R1");
        expect_reg(5, 8'h01, "R1");
        expect_reg(6, 8'h01, "R1");
        expect_reg(7, 8'h00, "R1");
        expect_reg(8, 8'h20, "R1");

        // R2 gating: no steps without osc_en, then three seconds
        idle(20);
        expect_reg(1, 8'h00, "R2");
        run_osc(3 * P);
        expect_reg(1, 8'h03, "R2");

        // R3 minute/hour carries with BCD digit rollover
        set_time(8'h20, 8'h23, 8'h07, 8'h14, 8'h02, 8'h12, 8'h39, 8'h59);
        expect_reg(1, 8'h59, "R9");
        run_osc(P);
        expect_reg(1, 8'h00, "R3");
        expect_reg(2, 8'h40, "R3");
        expect_reg(3, 8'h12, "R3");

        // R3 R4 R6 R7 end of 1999
        set_time(8'h19, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
        run_osc(P);
        expect_reg(3, 8'h00, "R3");
        expect_reg(5, 8'h01, "R4");
        expect_reg(6, 8'h01, "R6");
        expect_reg(7, 8'h00, "R6");
        expect_reg(8, 8'h20, "R6");
        expect_reg(4, 8'h01, "R7");

        // R4 30-day month and 31-day month
        set_time(8'h20, 8'h23, 8'h04, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59);
        run_osc(P);
        expect_reg(5, 8'h01, "R4");
        expect_reg(6, 8'h05, "R4");
        expect_reg(4, 8'h04, "R7");
        set_time(8'h20, 8'h23, 8'h01, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59);
        run_osc(P);
        expect_reg(5, 8'h31, "R4");
        expect_reg(6, 8'h01, "R4");

        // R5 leap rules
        set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        run_osc(P);
        expect_reg(5, 8'h29, "R5");
        set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        run_osc(P);
        expect_reg(5, 8'h01, "R5");
        expect_reg(6, 8'h03, "R5");
        set_time(8'h20, 8'h00, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        run_osc(P);
        expect_reg(5, 8'h29, "R5");
        set_time(8'h21, 8'h00, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        run_osc(P);
        expect_reg(5, 8'h01, "R5");
        set_time(8'h20, 8'h24, 8'h02, 8'h29, 8'h07, 8'h23, 8'h59, 8'h59);
        run_osc(P);
        expect_reg(6, 8'h03, "R5");
        expect_reg(4, 8'h01, "R7");

        // R8 snapshot freeze
        set_time(8'h20, 8'h25, 8'h06, 8'h10, 8'h02, 8'h08, 8'h00, 8'h10);
        wr_reg(0, 1);
        expect_reg(0, 8'h01, "R11");
        run_osc(3 * P);
        expect_reg(1, 8'h10, "R8");
        wr_reg(0, 0);
        expect_reg(1, 8'h10, "R8");
        run_osc(P);
        expect_reg(1, 8'h14, "R8");

        // R9 writes ignored outside EDIT
        wr_reg(1, 8'h45);
        expect_reg(1, 8'h14, "R9");
        wr_reg(0, 1);
        wr_reg(2, 8'h33);
        expect_reg(2, 8'h00, "R9");
        wr_reg(0, 0);
        idle(2);
        expect_reg(2, 8'h00, "R9");

        // R10 commit restarts the prescaler
        run_osc(2);
        wr_reg(0, 2);
        wr_reg(1, 8'h30);
        wr_reg(0, 0);
        idle(1);
        run_osc(P - 1);
        expect_reg(1, 8'h30, "R10");
        run_osc(1);
        expect_reg(1, 8'h31, "R10");

        // R11 control readback and unmapped addresses
        wr_reg(0, 3);
        expect_reg(0, 8'h03, "R11");
        expect_reg(12, 8'h00, "R11");
        expect_reg(9, 8'h00, "R11");
        wr_reg(0, 0);
        idle(4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule